// File: doc/BRIEF.md
# Square-Wave Tone Front End with Byte Command Decoder

This block is the command decoder and tone section of a four-voice sound generator. A host drives an 8-bit command byte and pulls an active-low strobe. The block turns the stream of bytes into register values:

- three 10-bit tone half-period values,
- four 4-bit loudness-reduction values,
- one 3-bit noise setting.

A byte with its top bit set names a destination and carries four data bits. A byte with its top bit clear supplies the upper six bits of the tone period that was named most recently.

A prescaler divides the master clock down to an internal step pulse. Its ratio is picked by a two-bit mode input. On every step pulse, each of three countdown channels decrements. When a channel's count runs out, it reloads from its period register and inverts its square-wave output. The step pulse, the register values and a one-cycle pulse that marks every noise-setting write are all brought out, so that a noise generator and a mixer elsewhere can use them.

Top module: `psg_tone_front`

## Requirements
- R1: A write of a byte with bit 7 = 1, bit 4 = 0 and bits 6:5 = c for c in 0..2 puts bits 3:0 into bits 3:0 of tone period c. Bits 9:4 of that period are left unchanged. Tone c becomes the remembered target.
- R2: A write of a byte with bit 7 = 0 puts bits 5:0 into bits 9:4 of the remembered tone period, provided the last byte with bit 7 = 1 was a tone write (R1).
- R3: A byte with bit 7 = 0 changes no register in two cases: when no tone write has occurred since reset, or when the most recent byte with bit 7 = 1 addressed a loudness or noise register.
- R4: A write of a byte with bit 7 = 1, bit 4 = 1 and bits 6:5 = c (0..3) puts bits 3:0 into loudness field c. Field c occupies bits 4c+3:4c of `atten`.
- R5: A write of a byte with bits 7:4 = 1110 puts bits 2:0 into `noise_ctrl`. Bit 2 is the noise type and bits 1:0 are the rate. `noise_wr` is high for exactly the one cycle that follows the write edge and for no other write.
- R6: A write is taken on the first rising clock edge at which `wr_n` is sampled low after having been high. Holding `wr_n` low for more cycles, even with a changing bus, writes nothing further.
- R7: `tick` is high for one cycle out of every 16 when `clk_mode` is 00 or 11, out of every 128 when it is 10, and on every cycle when it is 01.
- R8: Each tone output inverts once every P step pulses, where P is its period register. A period of 0 behaves as 1. The output never changes in a cycle without a step pulse.
- R9: A synchronous high `rst` clears all registers, the tone outputs, `tick` (in mode 00) and `noise_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_data | input | 8 | Command byte |
| wr_n | input | 1 | Write strobe, active low |
| clk_mode | input | 2 | Prescaler ratio select |
| tone_out | output | 3 | Square-wave bit of each tone channel |
| tone_period | output | 30 | Tone periods, channel c at bits 10c+9:10c |
| atten | output | 16 | Loudness fields, channel c at bits 4c+3:4c |
| noise_ctrl | output | 3 | Noise type and rate |
| tick | output | 1 | Internal step pulse |
| noise_wr | output | 1 | One-cycle pulse after a noise-setting write |

## Verification
The bench goes after the remembered-target rule. It sends upper-bits bytes before any target is set, and right after loudness and noise writes. A decoder that kept a stale tone target would corrupt a period in those cases.

It holds the strobe low while the bus changes. A level-sensitive capture would then rewrite the register with the later byte.

It measures toggle spacing with a period of 0. A counter without the zero clamp would wrap and stay silent for 1024 steps.

It measures prescaler gaps in every mode, including the second encoding of divide-by-16. A wrong mode decode shows up there as a gap of the wrong length.

// File: rtl/psg_pkg.sv
package psg_pkg;

    parameter int BUS_W    = 8;
    parameter int PERIOD_W = 10;
    parameter int ATT_W    = 4;
    parameter int NOISE_W  = 3;
    parameter int TONE_CH  = 3;
    parameter int ALL_CH   = 4;
    parameter int PRE_W    = 8;

    localparam int LOW_W = 4;
    localparam int HI_W  = PERIOD_W - LOW_W;
    localparam int CH_W  = 2;

    typedef enum logic [1:0] {
        MODE_DIV16   = 2'b00,
        MODE_DIV1    = 2'b01,
        MODE_DIV128  = 2'b10,
        MODE_DIV16_B = 2'b11
    } clk_mode_e;

    typedef struct packed {
        logic            valid;
        logic [CH_W-1:0] chan;
    } tone_sel_t;

    typedef struct packed {
        logic             is_latch;
        logic [CH_W-1:0]  chan;
        logic             to_att;
        logic [LOW_W-1:0] low;
        logic [HI_W-1:0]  high;
    } bus_byte_t;

    // terminal count of the prescaler for a given mode (ratio minus one)
    function automatic logic [PRE_W-1:0] div_last(input logic [1:0] mode);
        case (clk_mode_e'(mode))
            MODE_DIV1:   return PRE_W'(0);
            MODE_DIV128: return PRE_W'(127);
            default:     return PRE_W'(15);
        endcase
    endfunction

    function automatic bus_byte_t decode_byte(input logic [BUS_W-1:0] b);
        bus_byte_t r;
        r.is_latch = b[7];
        r.chan     = b[6:5];
        r.to_att   = b[4];
        r.low      = b[LOW_W-1:0];
        r.high     = b[HI_W-1:0];
        return r;
    endfunction

endpackage

// File: rtl/psg_prescale.sv
module psg_prescale
    import psg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] clk_mode,
    output logic       tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] last;

    assign last = div_last(clk_mode);
    // >= keeps a mode switch to a shorter ratio from running off the end
    assign tick = (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && clk_mode != 2'b01) |=> (!tick || clk_mode == 2'b01)); // R7

endmodule

// File: rtl/psg_bus_regs.sv
module psg_bus_regs
    import psg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BUS_W-1:0]            bus_data,
    input  logic                        wr_n,
    output logic [TONE_CH*PERIOD_W-1:0] tone_flat,
    output logic [ALL_CH*ATT_W-1:0]     att_flat,
    output logic [NOISE_W-1:0]          noise_q,
    output logic                        noise_wr
);

    logic                wr_q;
    logic                wr_fire;
    bus_byte_t           cmd;
    tone_sel_t           sel_q;
    logic [PERIOD_W-1:0] tone_q [TONE_CH];
    logic [ATT_W-1:0]    att_q  [ALL_CH];

    assign cmd     = decode_byte(bus_data);
    assign wr_fire = wr_q & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q     <= 1'b1;
            sel_q    <= '0;
            noise_q  <= '0;
            noise_wr <= 1'b0;
            for (int i = 0; i < TONE_CH; i++) tone_q[i] <= '0;
            for (int j = 0; j < ALL_CH; j++)  att_q[j]  <= '0;
        end else begin
            wr_q     <= wr_n;
            noise_wr <= 1'b0;
            if (wr_fire) begin
                if (cmd.is_latch) begin
                    if (cmd.to_att) begin
                        att_q[cmd.chan] <= cmd.low;
                        sel_q.valid     <= 1'b0;
                    end else if (cmd.chan >= CH_W'(TONE_CH)) begin
                        noise_q     <= cmd.low[NOISE_W-1:0];
                        noise_wr    <= 1'b1;
                        sel_q.valid <= 1'b0;
                    end else begin
                        tone_q[cmd.chan][LOW_W-1:0] <= cmd.low;
                        sel_q.valid <= 1'b1;
                        sel_q.chan  <= cmd.chan;
                    end
                end else if (sel_q.valid) begin
                    tone_q[sel_q.chan][PERIOD_W-1:LOW_W] <= cmd.high;
                end
            end
        end
    end

    for (genvar t = 0; t < TONE_CH; t++) begin : g_tone_flat
        assign tone_flat[t*PERIOD_W +: PERIOD_W] = tone_q[t];
    end
    for (genvar a = 0; a < ALL_CH; a++) begin : g_att_flat
        assign att_flat[a*ATT_W +: ATT_W] = att_q[a];
    end

    AST_DATA_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && !bus_data[7] && !sel_q.valid) |=> $stable(tone_flat)); // R3

    AST_NOISE_PULSE: assert property (@(posedge clk) disable iff (rst)
        noise_wr |=> !noise_wr); // R5

    AST_HELD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && !wr_q) |=> ($stable(tone_flat) && $stable(att_flat) && $stable(noise_q))); // R6

endmodule

// File: rtl/psg_tone_chan.sv
module psg_tone_chan
    import psg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                sq
);

    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W-1:0] reload;

    // period zero is clamped so the channel keeps running
    assign reload = (period == '0) ? PERIOD_W'(1) : period;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sq    <= 1'b0;
        end else if (tick) begin
            if (cnt_q <= PERIOD_W'(1)) begin
                cnt_q <= reload;
                sq    <= ~sq;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_TONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sq)); // R8

endmodule

// File: rtl/psg_tone_front.sv
module psg_tone_front
    import psg_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [BUS_W-1:0]            bus_data,
    input  logic                        wr_n,
    input  logic [1:0]                  clk_mode,
    output logic [TONE_CH-1:0]          tone_out,
    output logic [TONE_CH*PERIOD_W-1:0] tone_period,
    output logic [ALL_CH*ATT_W-1:0]     atten,
    output logic [NOISE_W-1:0]          noise_ctrl,
    output logic                        tick,
    output logic                        noise_wr
);

    psg_prescale u_pre (
        .clk      (clk),
        .rst      (rst),
        .clk_mode (clk_mode),
        .tick     (tick)
    );

    psg_bus_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_data  (bus_data),
        .wr_n      (wr_n),
        .tone_flat (tone_period),
        .att_flat  (atten),
        .noise_q   (noise_ctrl),
        .noise_wr  (noise_wr)
    );

    for (genvar c = 0; c < TONE_CH; c++) begin : g_chan
        psg_tone_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .period (tone_period[c*PERIOD_W +: PERIOD_W]),
            .sq     (tone_out[c])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (tone_out == '0 && noise_wr == 1'b0)); // R9

endmodule

// File: tb/test_psg_tone_front.sv
`timescale 1ns/1ps
module test_psg_tone_front;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_data;
    logic        wr_n;
    logic [1:0]  clk_mode;
    logic [2:0]  tone_out;
    logic [29:0] tone_period;
    logic [15:0] atten;
    logic [2:0]  noise_ctrl;
    logic        tick;
    logic        noise_wr;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    psg_tone_front i_psg_tone_front (
        .clk         (clk),
        .rst         (rst),
        .bus_data    (bus_data),
        .wr_n        (wr_n),
        .clk_mode    (clk_mode),
        .tone_out    (tone_out),
        .tone_period (tone_period),
        .atten       (atten),
        .noise_ctrl  (noise_ctrl),
        .tick        (tick),
        .noise_wr    (noise_wr)
    );

    // {byte, field select, expected field value, requirement number}
    // field select: 0..2 tone period c, 3..6 loudness c-3, 7 noise setting
    localparam logic [25:0] VEC [0:15] = '{
        {8'h05, 4'd0, 10'h000, 4'd3},
        {8'h8C, 4'd0, 10'h00C, 4'd1},
        {8'h11, 4'd0, 10'h11C, 4'd2},
        {8'hA7, 4'd1, 10'h007, 4'd1},
        {8'h3F, 4'd1, 10'h3F7, 4'd2},
        {8'h9A, 4'd3, 10'h00A, 4'd4},
        {8'h2A, 4'd1, 10'h3F7, 4'd3},
        {8'hF8, 4'd6, 10'h008, 4'd4},
        {8'hE5, 4'd7, 10'h005, 4'd5},
        {8'h15, 4'd1, 10'h3F7, 4'd3},
        {8'hC3, 4'd2, 10'h003, 4'd1},
        {8'h01, 4'd2, 10'h013, 4'd2},
        {8'hDF, 4'd5, 10'h00F, 4'd4},
        {8'h00, 4'd2, 10'h013, 4'd3},
        {8'hB5, 4'd4, 10'h005, 4'd4},
        {8'h8F, 4'd0, 10'h11F, 4'd1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int field(input int sel);
        if (sel < 3)      return int'(tone_period[sel*10 +: 10]);
        else if (sel < 7) return int'(atten[(sel-3)*4 +: 4]);
        else              return int'(noise_ctrl);
    endfunction

    logic nw_first, nw_second;

    task automatic wr(input logic [7:0] b);
        @(negedge clk);
        bus_data = b;
        wr_n     = 1'b0;
        @(negedge clk);
        nw_first = noise_wr;
        wr_n     = 1'b1;
        @(negedge clk);
        nw_second = noise_wr;
    endtask

    task automatic measure_tick(output int gap);
        int n;
        n = 0;
        @(negedge clk);
        while (!tick && n < 1000) begin @(negedge clk); n++; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!tick && gap < 1000);
    endtask

    task automatic measure_tone(input int idx, output int gap);
        logic p;
        int n;
        @(negedge clk);
        p = tone_out[idx];
        n = 0;
        while (tone_out[idx] == p && n < 5000) begin @(negedge clk); n++; end
        p = tone_out[idx];
        gap = 0;
        do begin @(negedge clk); gap++; end while (tone_out[idx] == p && gap < 5000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all): actual=timeout expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int g;
        rst      = 1'b1;
        bus_data = 8'h00;
        wr_n     = 1'b1;
        clk_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9 reset state
        chk("R9 tone_period", int'(tone_period), 0);
        chk("R9 atten", int'(atten), 0);
        chk("R9 noise_ctrl", int'(noise_ctrl), 0);
        chk("R9 tone_out", int'(tone_out), 0);
        chk("R9 tick", int'(tick), 0);
        chk("R9 noise_wr", int'(noise_wr), 0);

        // R1 R2 R3 R4 R5 vector walk
        for (int i = 0; i < 16; i++) begin
            logic [25:0] v;
            string tag;
            v = VEC[i];
            wr(v[25:18]);
            tag = $sformatf("R%0d vector %0d", v[3:0], i);
            chk(tag, field(int'(v[17:14])), int'(v[13:4]));
            chk($sformatf("R5 noise_wr pulse vector %0d", i), int'(nw_first),
                (v[17:14] == 4'd7) ? 1 : 0);
            chk($sformatf("R5 noise_wr drop vector %0d", i), int'(nw_second), 0);
        end

        // R6 held strobe: one write only
        @(negedge clk);
        bus_data = 8'h81;
        wr_n     = 1'b0;
        @(negedge clk);
        bus_data = 8'h82;
        repeat (4) @(negedge clk);
        chk("R6 held strobe", int'(tone_period[9:0]), 'h111);
        wr_n = 1'b1;
        wr(8'h82);
        chk("R6 new strobe", int'(tone_period[9:0]), 'h112);

        // R7 prescaler gaps
        measure_tick(g); chk("R7 mode 00", g, 16);
        clk_mode = 2'b11;
        measure_tick(g); measure_tick(g); chk("R7 mode 11", g, 16);
        clk_mode = 2'b10;
        measure_tick(g); measure_tick(g); chk("R7 mode 10", g, 128);
        clk_mode = 2'b01;
        measure_tick(g); measure_tick(g); chk("R7 mode 01", g, 1);

        // R8 tone spacing
        wr(8'h85); wr(8'h00);
        measure_tone(0, g); chk("R8 period 5 mode 01", g, 5);
        wr(8'hA0); wr(8'h00);
        measure_tone(1, g); chk("R8 period 0 mode 01", g, 1);
        clk_mode = 2'b00;
        wr(8'hC3); wr(8'h00);
        measure_tone(2, g); measure_tone(2, g); chk("R8 period 3 mode 00", g, 48);

        // R9 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 rerun tone_period", int'(tone_period), 0);
        chk("R9 rerun atten", int'(atten), 0);
        chk("R9 rerun tone_out", int'(tone_out), 0);
        wr(8'h3C);
        chk("R3 data after reset", int'(tone_period), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule